// File: doc/BRIEF.md
# Open-LED and Thermal Fault Monitor

This block watches a bank of constant-current LED channels and reports two kinds of trouble: an over-temperature condition and LEDs that are open circuit. It takes the latched per-channel on/off states, the active-low global output enable, a digital over-temperature flag and one digital comparator result per channel. The comparator result is high when that channel's output sits below the open-LED threshold. From these it builds the per-channel drive enables, with a staggered turn-on. It also produces an active-high pull-down enable for a shared, wire-ORed fault line, and a per-channel open-LED status word.

Each channel's status is sampled once, after the channel has been driving continuously for its stagger delay plus a settling window. The sample is held in a detector until the next rising edge of the latch-enable strobe. On that edge the whole word is handed to the serial shift register, with a one-cycle load pulse, and the detector is cleared. A channel that is off, or that has not yet completed its settling window, contributes 0. A second strobe that arrives before a minimum spacing has elapsed is flagged.

Top module: `lod_fault_monitor`

## Requirements
- R1: While `therm_hot` is 1 at a clock edge, `fault_pull` is 1 after that edge, whatever the values of `oe_n`, `chan_on` and `led_low`.
- R2: With `therm_hot` at 0, `fault_pull` after an edge is 1 exactly when, at that edge, `oe_n` is 0 and some channel k has both `chan_on[k]` and `led_low[k]` at 1.
- R3: With `oe_n` at 1 and `therm_hot` at 0, `fault_pull` stays 0 even when every `led_low` bit is 1.
- R4: A channel's request is `chan_on[k]` with `oe_n` at 0 and `therm_hot` at 0. `drive_en[k]` is 0 whenever the request is 0. Once the request has been held for k*STAGGER_CYC clock edges, `drive_en[k]` is 1, so channel 0 drives at once. Dropping the request, for example because of over-temperature, restarts the stagger.
- R5: Channel k captures `led_low[k]` at the first edge after its request has been held for k*STAGGER_CYC+SETTLE_CYC edges, and captures at most once per strobe interval. A channel whose request drops has its captured value cleared to 0.
- R6: On a strobe rising edge, meaning the first clock edge at which `le` is 1 after it was 0, `lod_word` takes the detector contents with bit k belonging to channel k. `lod_load` is 1 for that one cycle, and the detector is cleared. No sample is taken on that edge. With no open LED the word is all zeros.
- R7: `le_early` is 1 for the one cycle after a strobe rising edge that follows the previous one by fewer than LE_MIN_CYC clock edges. The first strobe after reset is never early.
- R8: After a synchronous reset (`rst_n` low at an edge), `fault_pull`, `lod_word`, `lod_load` and `le_early` are 0, and `drive_en` is 0 until the stagger restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| oe_n | input | 1 | Global output enable, active low |
| therm_hot | input | 1 | Over-temperature flag |
| chan_on | input | NUM_CH | Latched per-channel on/off states |
| led_low | input | NUM_CH | Per-channel output-below-threshold comparator results |
| le | input | 1 | Latch-enable strobe level |
| drive_en | output | NUM_CH | Staggered per-channel drive enables |
| fault_pull | output | 1 | Pull-down enable for the shared open-drain fault line |
| lod_word | output | NUM_CH | Open-LED status word handed to the shift register |
| lod_load | output | 1 | One-cycle pulse marking a new `lod_word` |
| le_early | output | 1 | Strobe arrived before the minimum spacing |

## Verification
`drive_en` is combinational, so it is checked shortly after the inputs change on a falling edge. After that it is checked again once exactly k*STAGGER_CYC rising edges have passed. `fault_pull`, `lod_word`, `lod_load` and `le_early` are registered and become valid one edge after the inputs or strobe rise that cause them, so the bench samples them on the next falling edge. Expected status words are queued when a strobe is raised and compared by a monitor whenever `lod_load` appears. The settling boundary is tested by raising the strobe on the exact edge where the last channel would sample, which must yield 0, and then again after a normal gap.

// File: rtl/lodmon_pkg.sv
// Package: shared helpers for the open-LED / thermal fault monitor.
// Assumes: widths are derived from cycle counts known at elaboration.
package lodmon_pkg;

    // Bits needed to hold values 0..maxval.
    function automatic int cnt_bits(input int maxval);
        return (maxval < 1) ? 1 : $clog2(maxval + 1);
    endfunction

endpackage

// File: rtl/lodmon_channel.sv
// Module: one channel's stagger timer and open-LED sampler.
// Assumes: req already folds in global enable and thermal flag; le_rise is
// a single-cycle pulse. Timer saturates at the sample point.
module lodmon_channel #(
    parameter int IDX         = 0,
    parameter int STAGGER_CYC = 4,
    parameter int SETTLE_CYC  = 40,
    parameter int TW          = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic led_low,
    input  logic le_rise,
    output logic drive_on,
    output logic det_bit
);
    localparam int ON_AT     = IDX * STAGGER_CYC;
    localparam int SAMPLE_AT = ON_AT + SETTLE_CYC;
    localparam logic [TW-1:0] ON_AT_V     = TW'(ON_AT);
    localparam logic [TW-1:0] SAMPLE_AT_V = TW'(SAMPLE_AT);

    logic [TW-1:0] timer_q;
    logic          done_q;
    logic          det_q;

    // Count held-request edges, capture status once per strobe interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            done_q  <= 1'b0;
            det_q   <= 1'b0;
        end else if (!req) begin
            timer_q <= '0;
            done_q  <= 1'b0;
            det_q   <= 1'b0;
        end else begin
            if (timer_q != SAMPLE_AT_V) timer_q <= timer_q + 1'b1;
            if (le_rise) begin
                done_q <= 1'b0;
                det_q  <= 1'b0;
            end else if (!done_q && timer_q == SAMPLE_AT_V) begin
                done_q <= 1'b1;
                det_q  <= led_low;
            end
        end
    end

    // Staggered drive: on once the request has lasted this channel's delay.
    always_comb drive_on = req && (timer_q >= ON_AT_V);

    assign det_bit = det_q;

    // R5: a captured 1 only appears after a full settle with the request held.
    p_det_after_settle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(det_q) |-> ($past(req) && $past(timer_q) == SAMPLE_AT_V));

    // R5: a dropped request leaves nothing captured.
    p_off_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !det_q);

endmodule

// File: rtl/lodmon_fault.sv
// Module: fault line combiner. Over-temperature always pulls; open-LED
// pulls only when the global enable is active and the channel is on.
// Assumes: led_low is already synchronous to clk.
module lodmon_fault #(
    parameter int NUM_CH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              therm_hot,
    input  logic [NUM_CH-1:0] chan_on,
    input  logic [NUM_CH-1:0] led_low,
    output logic              fault_pull
);
    logic open_seen;

    // Any enabled channel below threshold.
    always_comb open_seen = |(chan_on & led_low);

    // Register the pull-down enable.
    always_ff @(posedge clk) begin
        if (!rst_n) fault_pull <= 1'b0;
        else        fault_pull <= therm_hot | (!oe_n & open_seen);
    end

    p_therm_fault_r1: assert property (@(posedge clk) disable iff (!rst_n)
        therm_hot |=> fault_pull);

    p_oe_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n && !therm_hot) |=> !fault_pull);

endmodule

// File: rtl/lodmon_le_spacing.sv
// Module: measures edges between strobe rises and flags short gaps.
// Assumes: le_rise is a single-cycle pulse; counter saturates at LE_MIN_CYC.
module lodmon_le_spacing #(
    parameter int LE_MIN_CYC = 332
) (
    input  logic clk,
    input  logic rst_n,
    input  logic le_rise,
    output logic le_early
);
    localparam int CW = lodmon_pkg::cnt_bits(LE_MIN_CYC);
    localparam logic [CW-1:0] MIN_V = CW'(LE_MIN_CYC);

    logic [CW-1:0] gap_q;

    // Gap counter and early flag; starts saturated so the first strobe is fine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q    <= MIN_V;
            le_early <= 1'b0;
        end else begin
            le_early <= le_rise && (gap_q < MIN_V);
            if (le_rise)             gap_q <= CW'(1);
            else if (gap_q != MIN_V) gap_q <= gap_q + 1'b1;
        end
    end

    p_early_on_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        le_early |-> $past(le_rise));

endmodule

// File: rtl/lod_fault_monitor.sv
// Module: top of the open-LED and thermal fault monitor.
// Assumes: all inputs are synchronous to clk; le is held low at least one
// cycle between strobes.
module lod_fault_monitor #(
    parameter int NUM_CH      = 16,
    parameter int STAGGER_CYC = 4,
    parameter int SETTLE_CYC  = 40,
    parameter int LE_MIN_CYC  = 332
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              oe_n,
    input  logic              therm_hot,
    input  logic [NUM_CH-1:0] chan_on,
    input  logic [NUM_CH-1:0] led_low,
    input  logic              le,
    output logic [NUM_CH-1:0] drive_en,
    output logic              fault_pull,
    output logic [NUM_CH-1:0] lod_word,
    output logic              lod_load,
    output logic              le_early
);
    localparam int MAX_POINT = (NUM_CH - 1) * STAGGER_CYC + SETTLE_CYC;
    localparam int TW        = lodmon_pkg::cnt_bits(MAX_POINT);

    logic              le_q;
    logic              le_rise;
    logic [NUM_CH-1:0] req;
    logic [NUM_CH-1:0] det_vec;

    // Strobe edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) le_q <= 1'b0;
        else        le_q <= le;
    end

    always_comb le_rise = le && !le_q;

    // Per-channel drive request.
    always_comb req = chan_on & {NUM_CH{!oe_n && !therm_hot}};

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        lodmon_channel #(
            .IDX        (k),
            .STAGGER_CYC(STAGGER_CYC),
            .SETTLE_CYC (SETTLE_CYC),
            .TW         (TW)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req[k]),
            .led_low (led_low[k]),
            .le_rise (le_rise),
            .drive_on(drive_en[k]),
            .det_bit (det_vec[k])
        );
    end

    lodmon_fault #(.NUM_CH(NUM_CH)) u_fault (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe_n      (oe_n),
        .therm_hot (therm_hot),
        .chan_on   (chan_on),
        .led_low   (led_low),
        .fault_pull(fault_pull)
    );

    lodmon_le_spacing #(.LE_MIN_CYC(LE_MIN_CYC)) u_gap (
        .clk     (clk),
        .rst_n   (rst_n),
        .le_rise (le_rise),
        .le_early(le_early)
    );

    // Hand the detector word to the shift register on each strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lod_word <= '0;
            lod_load <= 1'b0;
        end else begin
            lod_load <= le_rise;
            if (le_rise) lod_word <= det_vec;
        end
    end

    p_therm_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        therm_hot |-> (drive_en == '0));

    p_load_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lod_load |=> !lod_load);

    p_word_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !lod_load |-> $stable(lod_word) || $past(le_rise));

endmodule

// File: tb/tb_lod_fault_monitor.sv
`timescale 1ns/1ps
module tb_lod_fault_monitor;
    localparam int N   = 16;
    localparam int ST  = 4;
    localparam int SET = 40;
    localparam int LM  = 332;

    logic         clk = 1'b0;
    logic         rst_n, oe_n, therm_hot, le;
    logic [N-1:0] chan_on, led_low;
    logic [N-1:0] drive_en, lod_word;
    logic         fault_pull, lod_load, le_early;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] exp_q[$];
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lod_fault_monitor #(.NUM_CH(N), .STAGGER_CYC(ST), .SETTLE_CYC(SET),
                        .LE_MIN_CYC(LM)) dut (
        .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .therm_hot(therm_hot),
        .chan_on(chan_on), .led_low(led_low), .le(le),
        .drive_en(drive_en), .fault_pull(fault_pull), .lod_word(lod_word),
        .lod_load(lod_load), .le_early(le_early));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: raise the strobe at a falling edge, queue the expected word,
    // then return at the falling edge after the rise edge with le low.
    task automatic le_fire(input logic [N-1:0] word, input logic early);
        exp_q.push_back(word);
        le = 1'b1;
        @(negedge clk);
        chk("R7 le_early", 32'(le_early), 32'(early));
        le = 1'b0;
    endtask

    // Monitor: compare every handed-over word against the queue (R6).
    always @(negedge clk) begin
        if (rst_n && lod_load) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R6 unexpected load actual=%h expected=none", lod_word);
            end else begin
                chk("R6 lod_word", 32'(lod_word), 32'(exp_q.pop_front()));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; oe_n = 1'b1; therm_hot = 1'b0; le = 1'b0;
        chan_on = '0; led_low = '0;
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 fault_pull", 32'(fault_pull), 0);
        chk("R8 lod_word", 32'(lod_word), 0);
        chk("R8 lod_load", 32'(lod_load), 0);
        chk("R8 le_early", 32'(le_early), 0);
        chk("R8 drive_en", 32'(drive_en), 0);
        rst_n = 1'b1;

        // R3: disabled globally, open LED masked
        chan_on = 16'hFFFF; led_low = 16'h0010;
        @(negedge clk);
        chk("R3 masked", 32'(fault_pull), 0);
        chk("R4 oe off", 32'(drive_en), 0);

        // R4 stagger, R2 fault
        oe_n = 1'b0;
        #1 chk("R4 ch0 immediate", 32'(drive_en), 32'h0001);
        @(negedge clk);
        chk("R2 open enabled", 32'(fault_pull), 1);
        repeat (3) @(negedge clk);
        chk("R4 after 4 edges", 32'(drive_en), 32'h0003);
        repeat (56) @(negedge clk);
        chk("R4 after 60 edges", 32'(drive_en), 32'hFFFF);
        repeat (50) @(negedge clk);
        // R5/R6 captured open channel 4
        le_fire(16'h0010, 1'b0);

        // R6 all-zero word, R7 exact minimum gap
        led_low = '0;
        repeat (LM - 1) @(negedge clk);
        le_fire(16'h0000, 1'b0);
        // R7 one edge short
        repeat (LM - 2) @(negedge clk);
        le_fire(16'h0000, 1'b1);

        // R5 boundary: strobe on the exact sampling edge of channel 15
        chan_on = '0;
        repeat (5) @(negedge clk);
        chan_on = 16'h8000; led_low = 16'h8000;
        repeat (100) @(negedge clk);
        le_fire(16'h0000, 1'b1);
        repeat (LM - 1) @(negedge clk);
        le_fire(16'h8000, 1'b0);

        // R1 thermal, R4 forced off and restart
        chan_on = 16'hFFFF; led_low = '0; therm_hot = 1'b1;
        #1 chk("R4 thermal off", 32'(drive_en), 0);
        @(negedge clk);
        chk("R1 thermal fault", 32'(fault_pull), 1);
        oe_n = 1'b1;
        @(negedge clk);
        chk("R1 thermal with oe high", 32'(fault_pull), 1);
        therm_hot = 1'b0; oe_n = 1'b0;
        #1 chk("R4 restart ch0", 32'(drive_en), 32'h0001);
        @(negedge clk);
        chk("R2 no open", 32'(fault_pull), 0);
        repeat (59) @(negedge clk);
        chk("R4 restart all", 32'(drive_en), 32'hFFFF);

        // R3 / R2 masking details
        oe_n = 1'b1; led_low = 16'hFFFF;
        #1 chk("R4 oe drop", 32'(drive_en), 0);
        @(negedge clk);
        chk("R3 all low masked", 32'(fault_pull), 0);
        oe_n = 1'b0;
        @(negedge clk);
        chk("R2 enabled fault", 32'(fault_pull), 1);
        chan_on = '0;
        @(negedge clk);
        chk("R2 off channels ignored", 32'(fault_pull), 0);

        repeat (3) @(negedge clk);
        chk("R6 queue drained", 32'(exp_q.size()), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule